// File: doc/BRIEF.md
# Four-Channel Shifted-Count PWM Generator

This block produces four pulse-width-modulated outputs from one shared free-running counter. Each output has its own 16-bit compare value. The counter is 31 bits wide. A programmable scale amount selects which 16-bit window of the counter the comparators see. Each added step of scale doubles the period without dividing the clock. All outputs are active-low. An output is driven low while the windowed count is below its compare value, and high for the rest of the period.

Software controls the block through a flat register space. A write strobe, an address and write data load the registers, and read data follows the address combinationally. The counter runs in one of two ways. In continuous mode it runs until software stops it. In single-period mode it runs one period and then stops itself. An optional zero-compare mode ends each period when the windowed count reaches channel 0's compare value, which allows periods that are not a power of two.

Top module: `pwm_quad_shift`

## Requirements
- R1: While reset is asserted, and right after it, the configuration register, the counter and all compare values are zero, and every `pwm_n` bit is 1.
- R2: The register offsets are: configuration at 0x00, counter at 0x08, windowed count at 0x10 (read only), and compare channel k at 0x20+4k. The configuration register holds the scale in bits [3:0], zero-compare in bit 9, continuous run in bit 12 and single-period run in bit 13. All other configuration bits read as 0. A compare register reads back only its low 16 bits. Any unmapped offset reads as 0.
- R3: The counter adds one on each clock while continuous run or single-period run is set. When both are clear, the counter holds its value.
- R4: The windowed count equals counter bits [scale+15:scale]. It can be read at offset 0x10.
- R5: `pwm_n[k]` is 0 exactly when the windowed count is below compare k. A compare value of 0 keeps the output at 1.
- R6: When the windowed count is 0xFFFF, every output is 1, even with a compare value of 0xFFFF.
- R7: When zero-compare is off, the counter returns to 0 on the clock after its low 16+scale bits are all ones. A period is therefore 2^(16+scale) clocks.
- R8: When zero-compare is on, the counter returns to 0 on the clock after the first cycle in which the windowed count equals compare 0.
- R9: At the end of a period, the single-period run bit clears itself. The counter then stays at 0 unless continuous run is set.
- R10: A compare write changes the output on the clock edge that stores it. Compare values have no shadow register.
- R11: A write to the counter register loads bits [30:0] of the write data. This write takes priority over counting and over the period wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_n | output | 4 | Active-low PWM outputs, one per channel |

## Verification
The counter and the windowed count can both be read back, so a counter that steps wrongly or holds wrongly shows up at the next read. The bench reads within one to a few clocks of the event. A wrong scale decode makes the read-back window and the output polarity disagree with the arithmetic expectation in the same cycle. A wrap at the wrong point, or a single-period bit that fails to clear, shows up one clock after the last count of the period as a non-zero counter or a set run bit. The directed wrap tests preload the counter just below the end of a period, so these faults appear within three clocks.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  // byte offsets of the register space
  localparam int unsigned OFF_CFG      = 'h00;
  localparam int unsigned OFF_CNT      = 'h08;
  localparam int unsigned OFF_WIN      = 'h10;
  localparam int unsigned OFF_CMP_BASE = 'h20;
  localparam int unsigned CMP_STRIDE   = 4;

  // configuration bit positions
  localparam int unsigned CFG_ZC_BIT   = 9;
  localparam int unsigned CFG_CONT_BIT = 12;
  localparam int unsigned CFG_ONCE_BIT = 13;

  typedef struct packed {
    logic once;
    logic cont;
    logic zero_cmp;
  } run_flags_t;
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int unsigned NCH     = 4,
  parameter int unsigned CMP_W   = 16,
  parameter int unsigned CNT_W   = 31,
  parameter int unsigned SCALE_W = 4,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       period_done,
  output logic [SCALE_W-1:0]         scale,
  output run_flags_t                 flags,
  output logic [NCH-1:0][CMP_W-1:0]  cmp,
  output logic                       cfg_wr,
  output logic                       cnt_load,
  output logic [CNT_W-1:0]           cnt_load_val
);

  logic [SCALE_W-1:0] scale_q, scale_d;
  run_flags_t         flags_q, flags_d;
  logic               flags_en;
  logic [NCH-1:0]     cmp_wr;
  logic [NCH-1:0][CMP_W-1:0] cmp_q;
  logic               unused_wbits;

  assign cfg_wr       = we && (addr == ADDR_W'(OFF_CFG));
  assign cnt_load     = we && (addr == ADDR_W'(OFF_CNT));
  assign cnt_load_val = wdata[CNT_W-1:0];
  assign unused_wbits = ^wdata[DATA_W-1:CNT_W];

  // next state of configuration
  always_comb begin
    scale_d  = cfg_wr ? wdata[SCALE_W-1:0] : scale_q;
    flags_d  = flags_q;
    flags_en = cfg_wr | period_done;
    if (cfg_wr) begin
      flags_d.zero_cmp = wdata[CFG_ZC_BIT];
      flags_d.cont     = wdata[CFG_CONT_BIT];
      flags_d.once     = wdata[CFG_ONCE_BIT];
    end else if (period_done) begin
      flags_d.once = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q <= '0;
    end else if (cfg_wr) begin
      scale_q <= scale_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    assign cmp_wr[i] = we && (addr == ADDR_W'(OFF_CMP_BASE + CMP_STRIDE * i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q[i] <= '0;
      end else if (cmp_wr[i]) begin
        cmp_q[i] <= wdata[CMP_W-1:0];
      end
    end
  end

  assign scale = scale_q;
  assign flags = flags_q;
  assign cmp   = cmp_q;

endmodule

// File: rtl/pwm_quad_counter.sv
module pwm_quad_counter #(
  parameter int unsigned CNT_W   = 31,
  parameter int unsigned CMP_W   = 16,
  parameter int unsigned SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               zero_cmp,
  input  logic [SCALE_W-1:0] scale,
  input  logic [CMP_W-1:0]   cmp0,
  input  logic               load,
  input  logic [CNT_W-1:0]   load_val,
  output logic [CNT_W-1:0]   cnt,
  output logic [CMP_W-1:0]   win,
  output logic               period_done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] shifted;
  logic [CNT_W-1:0] low_mask;
  logic             nat_end, cmp_end, wrap, cnt_en;
  logic             unused_hi;

  assign shifted   = cnt_q >> scale;
  assign win       = shifted[CMP_W-1:0];
  assign unused_hi = ^shifted[CNT_W-1:CMP_W];

  // bits below the window must all be ones for the last clock of a count
  assign low_mask = ~({CNT_W{1'b1}} << scale);
  assign nat_end  = (&win) && ((cnt_q & low_mask) == low_mask);
  assign cmp_end  = zero_cmp && (win == cmp0);
  assign wrap     = run && (nat_end || cmp_end);

  assign period_done = wrap && !load;
  assign cnt_en      = load | run;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (wrap) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pwm_quad_cmp.sv
module pwm_quad_cmp #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned CMP_W = 16
) (
  input  logic [CMP_W-1:0]          win,
  input  logic [NCH-1:0][CMP_W-1:0] cmp,
  output logic [NCH-1:0]            pwm_n
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // active (low) while the window lies below the threshold
    assign pwm_n[i] = ~(win < cmp[i]);
  end

endmodule

// File: rtl/pwm_quad_shift.sv
module pwm_quad_shift
  import pwm_quad_pkg::*;
#(
  parameter int unsigned NCH     = 4,
  parameter int unsigned CMP_W   = 16,
  parameter int unsigned CNT_W   = 31,
  parameter int unsigned SCALE_W = 4,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCH-1:0]    pwm_n
);

  logic [SCALE_W-1:0]        scale;
  run_flags_t                flags;
  logic [NCH-1:0][CMP_W-1:0] cmp;
  logic                      cfg_wr, cnt_load;
  logic [CNT_W-1:0]          cnt_load_val;
  logic [CNT_W-1:0]          cnt;
  logic [CMP_W-1:0]          win;
  logic                      period_done;
  logic                      run;

  assign run = flags.cont | flags.once;

  pwm_quad_regs #(
    .NCH(NCH), .CMP_W(CMP_W), .CNT_W(CNT_W),
    .SCALE_W(SCALE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (reg_we),
    .addr         (reg_addr),
    .wdata        (reg_wdata),
    .period_done  (period_done),
    .scale        (scale),
    .flags        (flags),
    .cmp          (cmp),
    .cfg_wr       (cfg_wr),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val)
  );

  pwm_quad_counter #(
    .CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)
  ) u_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .zero_cmp    (flags.zero_cmp),
    .scale       (scale),
    .cmp0        (cmp[0]),
    .load        (cnt_load),
    .load_val    (cnt_load_val),
    .cnt         (cnt),
    .win         (win),
    .period_done (period_done)
  );

  pwm_quad_cmp #(
    .NCH(NCH), .CMP_W(CMP_W)
  ) u_cmp (
    .win   (win),
    .cmp   (cmp),
    .pwm_n (pwm_n)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(OFF_CFG)) begin
      reg_rdata[SCALE_W-1:0]  = scale;
      reg_rdata[CFG_ZC_BIT]   = flags.zero_cmp;
      reg_rdata[CFG_CONT_BIT] = flags.cont;
      reg_rdata[CFG_ONCE_BIT] = flags.once;
    end else if (reg_addr == ADDR_W'(OFF_CNT)) begin
      reg_rdata = DATA_W'(cnt);
    end else if (reg_addr == ADDR_W'(OFF_WIN)) begin
      reg_rdata = DATA_W'(win);
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (reg_addr == ADDR_W'(OFF_CMP_BASE + CMP_STRIDE * i)) begin
          reg_rdata = DATA_W'(cmp[i]);
        end
      end
    end
  end

endmodule

module pwm_quad_shift_chk #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned CMP_W = 16,
  parameter int unsigned CNT_W = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             once,
  input logic             cfg_wr,
  input logic             cnt_load,
  input logic [CNT_W-1:0] cnt_load_val,
  input logic [CNT_W-1:0] cnt,
  input logic             period_done,
  input logic [CMP_W-1:0] win,
  input logic [CMP_W-1:0] cmp0,
  input logic [NCH-1:0]   pwm_n
);

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_load && !period_done) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_load) |=> $stable(cnt));

  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |=> (cnt == '0));

  a_r9_once_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (once && period_done && !cfg_wr) |=> !once);

  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> (cnt == $past(cnt_load_val)));

  a_r6_never_full: assert property (@(posedge clk) disable iff (!rst_n)
    (&win) |-> (&pwm_n));

  a_r5_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp0 == '0) |-> pwm_n[0]);

endmodule

bind pwm_quad_shift pwm_quad_shift_chk #(
  .NCH(NCH), .CMP_W(CMP_W), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run          (run),
  .once         (flags.once),
  .cfg_wr       (cfg_wr),
  .cnt_load     (cnt_load),
  .cnt_load_val (cnt_load_val),
  .cnt          (cnt),
  .period_done  (period_done),
  .win          (win),
  .cmp0         (cmp[0]),
  .pwm_n        (pwm_n)
);

// File: tb/test_pwm_quad_shift.sv
module test_pwm_quad_shift;

  logic        clk;
  logic        rst_n;
  logic        we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  pwm_n;
  int          n_tests;
  int          n_fail;

  localparam logic [7:0] A_CFG = 8'h00;
  localparam logic [7:0] A_CNT = 8'h08;
  localparam logic [7:0] A_WIN = 8'h10;

  // {scale[3:0], counter[31:0], compare[15:0], window[15:0], outputs_low}
  localparam logic [68:0] VEC [8] = '{
    {4'd0,  32'h0000_0005, 16'h0006, 16'h0005, 1'b1},
    {4'd0,  32'h0000_0006, 16'h0006, 16'h0006, 1'b0},
    {4'd4,  32'h0001_2345, 16'h1234, 16'h1234, 1'b0},
    {4'd4,  32'h0001_2345, 16'h1235, 16'h1234, 1'b1},
    {4'd15, 32'h7FFF_8000, 16'hFFFF, 16'hFFFF, 1'b0},
    {4'd15, 32'h7FFF_7FFF, 16'hFFFF, 16'hFFFE, 1'b1},
    {4'd0,  32'h0000_0000, 16'h0000, 16'h0000, 1'b0},
    {4'd8,  32'h00AB_CDEF, 16'hFFFF, 16'hABCD, 1'b1}
  };

  pwm_quad_shift i_pwm_quad_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (we),
    .reg_addr  (addr),
    .reg_wdata (wdata),
    .reg_rdata (rdata),
    .pwm_n     (pwm_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    n_tests = 0; n_fail = 0;
    we = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(A_CFG, d); check("R1 cfg", d, 32'h0);
    rd(A_CNT, d); check("R1 cnt", d, 32'h0);
    check("R1 pwm_n", {28'h0, pwm_n}, 32'hF);

    // R2: configuration bits and compare width
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, d); check("R2 cfg readback", d, 32'h0000_320F);
    wr(A_CFG, 32'h0);
    wr(8'h2C, 32'h0001_ABCD);
    rd(8'h2C, d); check("R2 cmp3 readback", d, 32'h0000_ABCD);
    rd(8'h04, d); check("R2 unmapped", d, 32'h0);

    // R4 R5 R6: table of window / compare vectors, counter stopped
    for (int v = 0; v < 8; v++) begin
      wr(A_CFG, {28'h0, VEC[v][68:65]});
      wr(A_CNT, VEC[v][64:33]);
      for (int ch = 0; ch < 4; ch++) wr(8'h20 + 8'(4 * ch), {16'h0, VEC[v][32:17]});
      rd(A_WIN, d); check($sformatf("R4 window vec%0d", v), d, {16'h0, VEC[v][16:1]});
      check($sformatf("R5/R6 pwm_n vec%0d", v), {28'h0, pwm_n},
            VEC[v][0] ? 32'h0 : 32'hF);
    end

    // R3: hold while stopped, count while continuous
    wr(A_CFG, 32'h0);
    wr(A_CNT, 32'd100);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd(A_CNT, d); check("R3 hold", d, 32'd100);
    wr(A_CFG, 32'h0000_1000);
    repeat (10) @(posedge clk);
    @(negedge clk);
    rd(A_CNT, d); check("R3 count", d, 32'd110);

    // R11: load overrides counting
    wr(A_CNT, 32'd500);
    rd(A_CNT, d); check("R11 load", d, 32'd500);
    @(posedge clk); @(negedge clk);
    rd(A_CNT, d); check("R11 resume", d, 32'd501);

    // R7: natural wrap at scale 2
    wr(A_CFG, 32'h0);
    wr(A_CNT, 32'h0003_FFFE);
    wr(A_CFG, 32'h0000_1002);
    @(posedge clk); @(negedge clk);
    rd(A_CNT, d); check("R7 last count", d, 32'h0003_FFFF);
    @(posedge clk); @(negedge clk);
    rd(A_CNT, d); check("R7 wrap", d, 32'h0);

    // R8: zero-compare period of four clocks
    wr(A_CFG, 32'h0);
    wr(A_CNT, 32'h0);
    wr(8'h20, 32'd3);
    wr(A_CFG, 32'h0000_1200);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 ch0 low at 2", {31'h0, pwm_n[0]}, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(A_CNT, d); check("R8 at match", d, 32'd3);
    check("R8 ch0 high at match", {31'h0, pwm_n[0]}, 32'h1);
    @(posedge clk); @(negedge clk);
    rd(A_CNT, d); check("R8 reset", d, 32'h0);
    check("R8 ch0 low after", {31'h0, pwm_n[0]}, 32'h0);

    // R9: single period stops itself
    wr(A_CFG, 32'h0);
    wr(A_CNT, 32'h0000_FFFD);
    wr(A_CFG, 32'h0000_2000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(A_CNT, d); check("R9 wrapped", d, 32'h0);
    rd(A_CFG, d); check("R9 once cleared", d, 32'h0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd(A_CNT, d); check("R9 stays stopped", d, 32'h0);

    // R10: compare write takes effect at once
    wr(A_CFG, 32'h0);
    wr(A_CNT, 32'd10);
    wr(8'h24, 32'd5);
    check("R10 ch1 before", {31'h0, pwm_n[1]}, 32'h1);
    wr(8'h24, 32'd20);
    check("R10 ch1 after", {31'h0, pwm_n[1]}, 32'h0);

    // R1: reset in the middle of a run
    wr(A_CFG, 32'h0000_1000);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    rd(A_CNT, d); check("R1 mid-run cnt", d, 32'h0);
    rd(A_CFG, d); check("R1 mid-run cfg", d, 32'h0);
    check("R1 mid-run pwm_n", {28'h0, pwm_n}, 32'hF);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(A_CNT, d); check("R1 stays idle", d, 32'h0);

    summary();
    $finish;
  end

endmodule